// File: doc/BRIEF.md
# Console serial port register interface

This block is the register file and handshake logic that sits between a processor bus and the shift engines of a simple asynchronous serial console port. A 2-bit address selects one of four byte registers: two control registers, a status register and a data register that reads the received byte and writes the byte to transmit. The data bus is logically inverted in both directions. A write stores the complement of the bus value, and a read drives the complement of the register.

On the receive side, a deserializer presents each byte with a one-cycle strobe and per-byte framing and parity error flags. The block accepts the byte only while the receiver is enabled, and it flags overrun when the previous byte is still unread. On the transmit side, the block masks each written byte to the programmed character length. In 7-bit mode with parity enabled, it puts the parity bit in bit 7. It hands the byte to a serializer with a load strobe and waits for an acknowledge before it reports the holding register empty. Three level interrupts follow the status bits. Reads of the status and data registers clear bits as a side effect.

Top module: `console_usart_regs`

## Requirements
- R1: Bus data is inverted both ways. Writing bus value V to control register 1 (address 0) or control register 2 (address 1) stores ~V. A read drives the complement of the selected register, so a register that was written reads back with the bus value that was written.
- R2: After reset both control registers and the receive register read as 0. The status register reads 0x41, which is transmit-empty plus DSR. Status bits, from bit 7 down to bit 0: modem-changed, DSR, carrier detect, framing error, parity error, overrun, data-received, transmit-empty.
- R3: A write to address 2 (status) changes no register.
- R4: A transmit write (address 3) masks the byte to the character length set by control 2 bits 7:6. The code 00 gives 8 bits, 01 gives 7, 10 gives 6 and 11 gives 5. The unused high bits become 0.
- R5: In 7-bit mode with the parity enable (control 1 bit 3) set, bit 7 of the transmit byte carries parity. Control 2 bit 4 set to 1 makes the total number of ones odd; set to 0 it makes the total even. Parity is never inserted in the other modes.
- R6: A transmit write clears transmit-empty. The block pulses tx_load for one cycle only while the transmitter enable (control 1 bit 1) is set and the holding register is full. It then issues no further load until tx_ack arrives, and tx_ack sets transmit-empty again.
- R7: A byte strobed in with rx_valid is stored and sets data-received only while the receiver enable (control 1 bit 2) is set. A byte strobed in while the receiver is disabled leaves both the receive register and the status unchanged.
- R8: A byte accepted while data-received is still set raises the overrun bit.
- R9: Reading the data register clears data-received. irq_rx follows data-received.
- R10: Writing control 1 with the receiver enable clear clears framing error, parity error, overrun and data-received.
- R11: A change on modem_dsr or modem_cd updates the DSR and carrier-detect status bits and sets modem-changed. A status read clears modem-changed.
- R12: irq_tx follows transmit-empty. irq_modem is high while control 1 bit 0 (modem-interrupt enable) and the status DSR bit are both 1.
- R13: An accepted byte with rx_frame_err sets framing error. An accepted byte with rx_par_err sets parity error only while the parity enable is set. Both flags hold until they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_rd | input | 1 | Read strobe, qualified by bus_sel; read side effects happen at the clock edge |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data, inverted |
| bus_rdata | output | 8 | Read data, inverted, combinational |
| rx_valid | input | 1 | Received byte strobe from the deserializer |
| rx_byte | input | 8 | Received byte |
| rx_frame_err | input | 1 | Framing error for the strobed byte |
| rx_par_err | input | 1 | Parity error for the strobed byte |
| tx_load | output | 1 | One-cycle load strobe to the serializer |
| tx_byte | output | 8 | Masked, parity-adjusted byte to transmit |
| tx_ack | input | 1 | Serializer has taken the byte |
| modem_dsr | input | 1 | Data-set-ready input level |
| modem_cd | input | 1 | Carrier-detect input level |
| irq_tx | output | 1 | Transmit interrupt level |
| irq_rx | output | 1 | Receive interrupt level |
| irq_modem | output | 1 | Modem-status interrupt level |

## Verification
The byte width and the address width are fixed by the register layout. The bench therefore builds the block with its package defaults: 8-bit registers and a 2-bit address. These defaults let the bench exercise every character-length code, both parity senses and the parity-disabled 7-bit case against a computed mask and parity. At the same width the bench checks the read-clear side effects, overrun stacking with sticky error flags, and the clear on receiver disable. It also covers a write to the status address and tx_load staying quiet while the transmitter is disabled.

// File: rtl/usart_pkg.sv
// Shared constants for the console serial port register block.
// Assumes an 8-bit register file with a 2-bit address.
package usart_pkg;
    localparam int DW = 8;
    localparam int AW = 2;

    typedef enum logic [AW-1:0] {
        A_CTRL1 = 2'd0,
        A_CTRL2 = 2'd1,
        A_STAT  = 2'd2,
        A_DATA  = 2'd3
    } reg_addr_e;

    // control 1 bit positions
    localparam int C1_PAREN = 3;
    localparam int C1_RXEN  = 2;
    localparam int C1_TXEN  = 1;
    localparam int C1_DTR   = 0;
    // control 2 fields
    localparam int C2_LEN_HI = 7;
    localparam int C2_LEN_LO = 6;
    localparam int C2_ODD    = 4;

    // Mask that keeps the low bits of the programmed character length.
    function automatic logic [DW-1:0] len_mask(input logic [1:0] code);
        return {DW{1'b1}} >> code;
    endfunction
endpackage

// File: rtl/usart_ctrl_regs.sv
// Holds the two control registers written from the bus.
// Assumes the write data is already de-inverted by the top.
module usart_ctrl_regs
    import usart_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_c1,
    input  logic          wr_c2,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl1,
    output logic [DW-1:0] ctrl2
);
    // Capture control writes; both registers clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl1 <= '0;
            ctrl2 <= '0;
        end else begin
            if (wr_c1) ctrl1 <= wdata;
            if (wr_c2) ctrl2 <= wdata;
        end
    end

    AST_C1_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c1 |=> ctrl1 == $past(wdata)); // R1
endmodule

// File: rtl/usart_tx_path.sv
// Transmit holding register: masks to character length, inserts 7-bit
// parity, and hands the byte to the serializer with a load/ack handshake.
// Assumes tx_ack arrives at most once per load.
module usart_tx_path
    import usart_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    len_code,
    input  logic          odd_par,
    input  logic          par_en,
    input  logic          tx_en,
    input  logic          tx_ack,
    output logic          thre,
    output logic          tx_load,
    output logic [DW-1:0] tx_byte
);
    logic [DW-1:0] masked;
    logic [DW-1:0] shaped;
    logic          par_bit;
    logic          busy;

    // Mask the incoming byte to its length and place parity in 7-bit mode.
    always_comb begin
        masked  = wdata & len_mask(len_code);
        par_bit = odd_par ? ~(^masked[DW-2:0]) : (^masked[DW-2:0]);
        shaped  = masked;
        if (len_code == 2'b01 && par_en)
            shaped[DW-1] = par_bit;
    end

    // Holding register, empty flag and serializer handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte <= '0;
            thre    <= 1'b1;
            busy    <= 1'b0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= tx_en && !thre && !busy;
            if (tx_en && !thre && !busy) busy <= 1'b1;
            if (tx_ack) begin
                busy <= 1'b0;
                thre <= 1'b1;
            end
            if (wr_data) begin
                tx_byte <= shaped;
                thre    <= 1'b0;
            end
        end
    end

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load); // R6
    AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ack && !wr_data) |=> thre); // R6
    AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> !thre || tx_ack); // R6
endmodule

// File: rtl/usart_rx_path.sv
// Receive holding register with data-received, overrun, framing and
// parity flags. Assumes rx_valid is a one-cycle strobe per byte.
module usart_rx_path
    import usart_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_frame_err,
    input  logic          rx_par_err,
    input  logic          rx_en,
    input  logic          par_chk,
    input  logic          clr_flags,
    input  logic          rd_data,
    output logic [DW-1:0] rcv,
    output logic          dr,
    output logic          oe,
    output logic          fe,
    output logic          pe
);
    logic accept;
    assign accept = rx_valid && rx_en;

    // Accept bytes, track errors; a receiver-disable write clears all flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcv <= '0;
            dr  <= 1'b0;
            oe  <= 1'b0;
            fe  <= 1'b0;
            pe  <= 1'b0;
        end else begin
            if (rd_data) dr <= 1'b0;
            if (accept) begin
                rcv <= rx_byte;
                dr  <= 1'b1;
                if (dr) oe <= 1'b1;
                if (rx_frame_err) fe <= 1'b1;
                if (rx_par_err && par_chk) pe <= 1'b1;
            end
            if (clr_flags) begin
                dr <= 1'b0;
                oe <= 1'b0;
                fe <= 1'b0;
                pe <= 1'b0;
            end
        end
    end

    AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dr && !clr_flags) |=> oe); // R8
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !accept) |=> !dr); // R9
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_en) |=> $stable(rcv)); // R7
endmodule

// File: rtl/usart_modem.sv
// Samples the modem status inputs and flags any change until status is read.
// Assumes the inputs are already synchronous to clk.
module usart_modem (
    input  logic clk,
    input  logic rst_n,
    input  logic modem_dsr,
    input  logic modem_cd,
    input  logic rd_stat,
    output logic dsr,
    output logic cd,
    output logic msc
);
    logic change;
    assign change = (modem_dsr != dsr) || (modem_cd != cd);

    // Track input levels; a change wins over a same-cycle status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsr <= 1'b1;
            cd  <= 1'b0;
            msc <= 1'b0;
        end else begin
            dsr <= modem_dsr;
            cd  <= modem_cd;
            if (change)       msc <= 1'b1;
            else if (rd_stat) msc <= 1'b0;
        end
    end

    AST_MSC_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !change) |=> !msc); // R11
    AST_MSC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> msc); // R11
endmodule

// File: rtl/console_usart_regs.sv
// Top of the console serial port register interface: inverted bus decode,
// read mux with read side effects, and interrupt levels.
// Assumes a single-cycle bus access; reads are combinational.
module console_usart_regs
    import usart_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_frame_err,
    input  logic          rx_par_err,
    output logic          tx_load,
    output logic [DW-1:0] tx_byte,
    input  logic          tx_ack,
    input  logic          modem_dsr,
    input  logic          modem_cd,
    output logic          irq_tx,
    output logic          irq_rx,
    output logic          irq_modem
);
    logic [DW-1:0] wdata_pos;
    logic [DW-1:0] ctrl1, ctrl2, status, rd_mux, rcv;
    logic          wr_c1, wr_c2, wr_data, rd_stat, rd_data;
    logic          thre, dr, oe, fe, pe, dsr, cd, msc;

    // Decode strobes and undo the bus inversion.
    always_comb begin
        wdata_pos = ~bus_wdata;
        wr_c1   = bus_sel && bus_wr && bus_addr == A_CTRL1;
        wr_c2   = bus_sel && bus_wr && bus_addr == A_CTRL2;
        wr_data = bus_sel && bus_wr && bus_addr == A_DATA;
        rd_stat = bus_sel && bus_rd && bus_addr == A_STAT;
        rd_data = bus_sel && bus_rd && bus_addr == A_DATA;
    end

    usart_ctrl_regs u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_c1(wr_c1), .wr_c2(wr_c2),
        .wdata(wdata_pos), .ctrl1(ctrl1), .ctrl2(ctrl2)
    );

    usart_tx_path u_tx (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wdata(wdata_pos),
        .len_code(ctrl2[C2_LEN_HI:C2_LEN_LO]), .odd_par(ctrl2[C2_ODD]),
        .par_en(ctrl1[C1_PAREN]), .tx_en(ctrl1[C1_TXEN]), .tx_ack(tx_ack),
        .thre(thre), .tx_load(tx_load), .tx_byte(tx_byte)
    );

    usart_rx_path u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err),
        .rx_en(ctrl1[C1_RXEN]), .par_chk(ctrl1[C1_PAREN]),
        .clr_flags(wr_c1 && !wdata_pos[C1_RXEN]), .rd_data(rd_data),
        .rcv(rcv), .dr(dr), .oe(oe), .fe(fe), .pe(pe)
    );

    usart_modem u_modem (
        .clk(clk), .rst_n(rst_n), .modem_dsr(modem_dsr), .modem_cd(modem_cd),
        .rd_stat(rd_stat), .dsr(dsr), .cd(cd), .msc(msc)
    );

    // Assemble status, select the read register and invert onto the bus.
    always_comb begin
        status = {msc, dsr, cd, fe, pe, oe, dr, thre};
        unique case (bus_addr)
            A_CTRL1: rd_mux = ctrl1;
            A_CTRL2: rd_mux = ctrl2;
            A_STAT:  rd_mux = status;
            default: rd_mux = rcv;
        endcase
        bus_rdata = ~rd_mux;
    end

    // Interrupt levels follow status bits.
    always_comb begin
        irq_tx    = thre;
        irq_rx    = dr;
        irq_modem = ctrl1[C1_DTR] && dsr;
    end

    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_STAT) |=>
            $stable(ctrl1) && $stable(ctrl2)); // R3
    AST_RX_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c1 && !wdata_pos[C1_RXEN]) |=> !irq_rx && status[4:2] == 3'b000); // R10
endmodule

// File: tb/console_usart_regs_test.sv
module console_usart_regs_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst_n = 0;
    logic       bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 8'hFF, bus_rdata;
    logic       rx_valid = 0, rx_frame_err = 0, rx_par_err = 0;
    logic [7:0] rx_byte = 0, tx_byte;
    logic       tx_load, tx_ack = 0;
    logic       modem_dsr = 1, modem_cd = 0;
    logic       irq_tx, irq_rx, irq_modem;

    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    console_usart_regs uut (.*);

    // {ctrl1, ctrl2, written byte, expected tx byte}
    localparam logic [31:0] VEC [8] = '{
        {8'h02, 8'h00, 8'hA5, 8'hA5},  // 8 bits
        {8'h02, 8'h40, 8'hFF, 8'h7F},  // 7 bits, no parity
        {8'h0A, 8'h40, 8'h07, 8'h87},  // 7 bits even parity
        {8'h0A, 8'h50, 8'h07, 8'h07},  // 7 bits odd parity
        {8'h0A, 8'h50, 8'h03, 8'h83},  // 7 bits odd parity
        {8'h02, 8'h80, 8'hFF, 8'h3F},  // 6 bits
        {8'h0A, 8'hC0, 8'hFF, 8'h1F},  // 5 bits, parity ignored
        {8'h0A, 8'h00, 8'h7E, 8'h7E}   // 8 bits, parity ignored
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = ~v;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = 8'hFF;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v, output logic [7:0] raw);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 raw = bus_rdata; v = ~bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic rx_strobe(input logic [7:0] b, input logic ferr, input logic perr);
        @(negedge clk);
        rx_valid = 1; rx_byte = b; rx_frame_err = ferr; rx_par_err = perr;
        @(negedge clk);
        rx_valid = 0; rx_frame_err = 0; rx_par_err = 0;
    endtask

    task automatic ack();
        @(negedge clk); tx_ack = 1;
        @(negedge clk); tx_ack = 0;
    endtask

    task automatic wait_load(input string req, output bit seen);
        seen = 0;
        for (int k = 0; k < 6 && !seen; k++) begin
            @(negedge clk);
            if (tx_load) seen = 1;
        end
        check(req, {7'd0, seen}, 8'h01);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v, raw;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // reset state, R2 and R1 inversion
        rd(2'd0, v, raw); check("R1 R2 raw ctrl1 after reset", raw, 8'hFF);
        rd(2'd1, v, raw); check("R2 ctrl2 reset", v, 8'h00);
        rd(2'd2, v, raw); check("R2 status reset", v, 8'h41);
        rd(2'd3, v, raw); check("R2 receive reset", v, 8'h00);
        check("R12 irq_tx at reset", {7'd0, irq_tx}, 8'h01);
        check("R12 irq_modem at reset", {7'd0, irq_modem}, 8'h00);

        // control readback, R1
        wr(2'd0, 8'hA5); rd(2'd0, v, raw); check("R1 ctrl1 readback", v, 8'hA5);
        check("R1 raw inverted", raw, 8'h5A);
        wr(2'd1, 8'h3C); rd(2'd1, v, raw); check("R1 ctrl2 readback", v, 8'h3C);
        check("R12 irq_modem dtr and dsr", {7'd0, irq_modem}, 8'h01);

        // status write ignored, R3
        wr(2'd2, 8'h00);
        rd(2'd2, v, raw); check("R3 status after write", v, 8'h41);
        rd(2'd0, v, raw); check("R3 ctrl1 after status write", v, 8'hA5);

        // transmit vectors, R4 R5 R6
        for (int i = 0; i < 8; i++) begin
            wr(2'd1, VEC[i][23:16]);
            wr(2'd0, VEC[i][31:24]);
            wr(2'd3, VEC[i][15:8]);
            check("R6 irq_tx low after write", {7'd0, irq_tx}, 8'h00);
            wait_load("R6 load issued", seen);
            check("R4 R5 tx byte", tx_byte, VEC[i][7:0]);
            ack();
            check("R6 R12 irq_tx after ack", {7'd0, irq_tx}, 8'h01);
        end

        // transmitter disabled holds the byte, R6
        wr(2'd1, 8'h00); wr(2'd0, 8'h00); wr(2'd3, 8'h55);
        seen = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); if (tx_load) seen = 1;
        end
        check("R6 no load while disabled", {7'd0, seen}, 8'h00);
        rd(2'd2, v, raw); check("R6 status full while disabled", v, 8'h40);
        wr(2'd0, 8'h02);
        wait_load("R6 load after enable", seen);
        check("R6 tx byte after enable", tx_byte, 8'h55);
        ack();

        // receive, R7 R9
        wr(2'd0, 8'h04);
        rx_strobe(8'h3C, 0, 0);
        check("R9 irq_rx set", {7'd0, irq_rx}, 8'h01);
        rd(2'd2, v, raw); check("R7 status dr", v, 8'h43);
        rd(2'd3, v, raw); check("R7 received byte", v, 8'h3C);
        check("R9 irq_rx cleared by read", {7'd0, irq_rx}, 8'h00);

        // receiver disabled, R7
        wr(2'd0, 8'h00);
        rx_strobe(8'h11, 1, 1);
        check("R7 disabled no irq_rx", {7'd0, irq_rx}, 8'h00);
        rd(2'd2, v, raw); check("R7 disabled status", v, 8'h41);
        rd(2'd3, v, raw); check("R7 disabled keeps byte", v, 8'h3C);

        // overrun and errors, R8 R13
        wr(2'd0, 8'h0C);
        rx_strobe(8'h01, 0, 1);
        rx_strobe(8'h02, 1, 0);
        rd(2'd2, v, raw); check("R8 R13 status overrun", v, 8'h5F);
        rd(2'd3, v, raw); check("R8 latest byte", v, 8'h02);
        rd(2'd2, v, raw); check("R13 errors sticky", v, 8'h5D);

        // parity error ignored without parity enable, R13
        wr(2'd0, 8'h00); wr(2'd0, 8'h04);
        rx_strobe(8'h09, 0, 1);
        rd(2'd2, v, raw); check("R13 parity unchecked", v, 8'h43);

        // receiver disable clears, R10
        rx_strobe(8'h0A, 1, 0);
        wr(2'd0, 8'h00);
        rd(2'd2, v, raw); check("R10 flags cleared", v, 8'h41);

        // modem change, R11 R12
        wr(2'd0, 8'h01);
        @(negedge clk); modem_dsr = 0;
        repeat (2) @(negedge clk);
        check("R12 irq_modem dsr low", {7'd0, irq_modem}, 8'h00);
        rd(2'd2, v, raw); check("R11 dsr change", v, 8'h81);
        rd(2'd2, v, raw); check("R11 msc cleared", v, 8'h01);
        @(negedge clk); modem_cd = 1;
        repeat (2) @(negedge clk);
        rd(2'd2, v, raw); check("R11 cd change", v, 8'hA1);
        rd(2'd2, v, raw); check("R11 cd steady", v, 8'h21);
        @(negedge clk); modem_dsr = 1; modem_cd = 0;
        repeat (2) @(negedge clk);
        check("R12 irq_modem restored", {7'd0, irq_modem}, 8'h01);
        rd(2'd2, v, raw); check("R11 restore change", v, 8'hC1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule